// File: doc/BRIEF.md
# Crossbar Slave-Port Configuration Register Bank

This block holds the per-slave-port settings of a multi-port crossbar switch. Each slave port has two 32-bit registers. One is a priority word that the arbitration logic reads. The other is a control word whose top bit is a write lock. Both registers of every configured port are exported on flat buses so that the arbiters can use them directly. The arbiters and the switch datapath are not part of this block.

Software reaches the registers through a simple request interface. A request carries an offset within a 4 KiB window, write data, an access size, a direction flag and a privilege flag. Every transfer takes exactly two clock cycles. The block then reports completion with a one-cycle done pulse, together with an error flag. The error flag is raised for unprivileged accesses, for accesses narrower than a word, for offsets that hold no register, and for writes to a locked port. A rejected access changes nothing.

Top module: `xbar_cfg_regs`

## Requirements
- R1: A request sampled with `req_valid` high at rising edge E1, while no transfer is in flight, produces `done` high only in the cycle that follows the next edge E2. `done` is low after E1 and low again after E3. A new request may be presented in the done cycle.
- R2: A request with `priv` low completes with `err` high. It writes no register and returns zero read data.
- R3: Only `size` = 2'b10 (32-bit) is accepted. Sizes 2'b00 (byte), 2'b01 (half) and 2'b11 complete with `err` high and no register change.
- R4: These offsets hold no register and complete with `err` high: any offset within a port slot other than 0x00 and 0x10, any offset in the slot of a port index at or above NPORT, and any offset with bit 11 set.
- R5: Bit 31 of a port's control word is its lock. While it is set, every write to either register of that port completes with `err` high and leaves both registers unchanged. Reads of that port still succeed. Only reset clears the lock.
- R6: After reset every priority word reads 0x76543210 and every control word reads 0x00000000.
- R7: Port p has its priority word at offset p*0x100 + 0x00 and its control word at p*0x100 + 0x10. An accepted write stores all 32 bits of `wdata`, and an accepted read returns the stored word.
- R8: `prio_o[32p+31:32p]` and `ctrl_o[32p+31:32p]` always show port p's current words. They change at the same edge that raises `done` for an accepted write.
- R9: `rdata` is zero in every cycle except the done cycle of an accepted read. `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Offset within the register window |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Privileged access flag |
| rdata | output | 32 | Read data, valid in the done cycle |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Transfer rejected, qualified by done |
| prio_o | output | 32*NPORT | Priority words of all ports |
| ctrl_o | output | 32*NPORT | Control words of all ports |

## Verification
The bench builds the block with NPORT = 6, the default. This leaves the slots of port indices 6 and 7 inside the window but unimplemented, so the out-of-count decode branch of R4 can be reached, as can the bit-11 region above it. Six ports are also enough to lock one port while a neighbour stays writable. Both exported buses are compared against the model after every edge of every transfer.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
    localparam int          DATA_W     = 32;
    localparam int          WIN_AW     = 12;
    localparam int          PORT_LSB   = 8;
    localparam int          PIDX_W     = 3;
    localparam int          MAX_PORTS  = 1 << PIDX_W;
    localparam int          LOCK_BIT   = 31;
    localparam logic [7:0]  PRIO_OFS   = 8'h00;
    localparam logic [7:0]  CTRL_OFS   = 8'h10;
    localparam logic [1:0]  SZ_WORD    = 2'b10;
    localparam logic [31:0] PRIO_RESET = 32'h7654_3210;
    localparam logic [31:0] CTRL_RESET = 32'h0000_0000;

    typedef struct packed {
        logic [DATA_W-1:0] prio;
        logic [DATA_W-1:0] ctrl;
    } port_regs_t;

    typedef struct packed {
        logic              stg_vld;
        logic              stg_wr;
        logic              stg_priv;
        logic [1:0]        stg_size;
        logic [WIN_AW-1:0] stg_addr;
        logic [DATA_W-1:0] stg_wdata;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;
endpackage

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
    import xbar_cfg_pkg::*;
#(
    parameter int NPORT = 6
) (
    input  logic [WIN_AW-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              priv_i,
    input  logic              wr_i,
    input  logic [NPORT-1:0]  lock_i,
    output logic [PIDX_W-1:0] port_o,
    output logic              sel_ctrl_o,
    output logic              err_o
);
    logic [PORT_LSB-1:0] ofs;
    logic                top_ok;
    logic                port_ok;
    logic                ofs_ok;
    logic                locked;

    always_comb begin
        port_o     = addr_i[PORT_LSB +: PIDX_W];
        ofs        = addr_i[PORT_LSB-1:0];
        top_ok     = (addr_i[WIN_AW-1:PORT_LSB+PIDX_W] == '0);
        port_ok    = (32'(port_o) < NPORT);
        sel_ctrl_o = (ofs == CTRL_OFS);
        ofs_ok     = (ofs == PRIO_OFS) || (ofs == CTRL_OFS);
        locked     = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (port_o == PIDX_W'(i)) locked = lock_i[i];
        end
        err_o = !priv_i || (size_i != SZ_WORD) || !top_ok || !port_ok
              || !ofs_ok || (wr_i && locked);
    end
endmodule

// File: rtl/xbar_cfg_port.sv
module xbar_cfg_port
    import xbar_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_prio_i,
    input  logic              we_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] prio_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              lock_o
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_prio_i) regs_d.prio = wdata_i;
        if (we_ctrl_i) regs_d.ctrl = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.prio <= PRIO_RESET;
            regs_q.ctrl <= CTRL_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign prio_o = regs_q.prio;
    assign ctrl_o = regs_q.ctrl;
    assign lock_o = regs_q.ctrl[LOCK_BIT];

    // R5: a set lock never clears before reset
    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl[LOCK_BIT] |=> regs_q.ctrl[LOCK_BIT]);

    // R5: a locked port never changes
    p_lock_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl[LOCK_BIT] |=> ($stable(regs_q.prio) && $stable(regs_q.ctrl)));
endmodule

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_cfg_pkg::*;
#(
    parameter int NPORT = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [WIN_AW-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic                    req_priv,
    output logic [DATA_W-1:0]       rdata,
    output logic                    done,
    output logic                    err,
    output logic [NPORT*DATA_W-1:0] prio_o,
    output logic [NPORT*DATA_W-1:0] ctrl_o
);
    localparam int BUS_W = NPORT * DATA_W;

    ctl_state_t st_d, st_q;

    logic [NPORT-1:0]  lock_vec;
    logic [NPORT-1:0]  we_prio;
    logic [NPORT-1:0]  we_ctrl;
    logic [PIDX_W-1:0] dec_port;
    logic              dec_ctrl;
    logic              dec_err;
    logic [DATA_W-1:0] rd_word;
    logic              accept;

    xbar_cfg_decode #(.NPORT(NPORT)) u_dec (
        .addr_i     (st_q.stg_addr),
        .size_i     (st_q.stg_size),
        .priv_i     (st_q.stg_priv),
        .wr_i       (st_q.stg_wr),
        .lock_i     (lock_vec),
        .port_o     (dec_port),
        .sel_ctrl_o (dec_ctrl),
        .err_o      (dec_err)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xbar_cfg_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_prio_i (we_prio[p]),
            .we_ctrl_i (we_ctrl[p]),
            .wdata_i   (st_q.stg_wdata),
            .prio_o    (prio_o[p*DATA_W +: DATA_W]),
            .ctrl_o    (ctrl_o[p*DATA_W +: DATA_W]),
            .lock_o    (lock_vec[p])
        );
    end

    always_comb begin
        accept  = st_q.stg_vld && !dec_err;
        rd_word = '0;
        we_prio = '0;
        we_ctrl = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (dec_port == PIDX_W'(p)) begin
                rd_word    = dec_ctrl ? ctrl_o[p*DATA_W +: DATA_W]
                                      : prio_o[p*DATA_W +: DATA_W];
                we_prio[p] = accept && st_q.stg_wr && !dec_ctrl;
                we_ctrl[p] = accept && st_q.stg_wr && dec_ctrl;
            end
        end

        st_d         = st_q;
        st_d.stg_vld = 1'b0;
        if (!st_q.stg_vld && req_valid) begin
            st_d.stg_vld   = 1'b1;
            st_d.stg_wr    = req_write;
            st_d.stg_priv  = req_priv;
            st_d.stg_size  = req_size;
            st_d.stg_addr  = req_addr;
            st_d.stg_wdata = req_wdata;
        end
        st_d.done  = st_q.stg_vld;
        st_d.err   = st_q.stg_vld && dec_err;
        st_d.rdata = (accept && !st_q.stg_wr) ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign done  = st_q.done;
    assign err   = st_q.err;

    // R1: a staged request completes at the very next edge
    p_done_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stg_vld |=> done);

    // R1: done only follows a staged request
    p_done_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q.stg_vld));

    // R2: unprivileged access is rejected
    p_unpriv_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg_vld && !st_q.stg_priv) |=> (done && err));

    // R3: non-word access is rejected
    p_narrow_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg_vld && st_q.stg_size != SZ_WORD) |=> err);

    // R9: quiet read data outside a good read, error only with done
    p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || err) |-> (rdata == '0));
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8: no exported word moves on a rejected or read transfer
    p_export_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg_vld && (dec_err || !st_q.stg_wr)) |=>
            ($stable(prio_o) && $stable(ctrl_o)));

    logic [BUS_W-1:0] unused_bus;
    assign unused_bus = '0;
endmodule

// File: tb/xbar_cfg_regs_test.sv
module xbar_cfg_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic [1:0]       req_size = 2'b10;
    logic             req_write = 1'b0;
    logic             req_priv = 1'b1;
    logic [31:0]      rdata;
    logic             done;
    logic             err;
    logic [NP*32-1:0] prio_o;
    logic [NP*32-1:0] ctrl_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] m_prio [NP];
    logic [31:0] m_ctrl [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_cfg_regs #(.NPORT(NP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_size(req_size), .req_write(req_write),
        .req_priv(req_priv), .rdata(rdata), .done(done), .err(err),
        .prio_o(prio_o), .ctrl_o(ctrl_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_exports(input string req);
        for (int p = 0; p < NP; p++) begin
            chk({req, " prio export"}, prio_o[p*32 +: 32], m_prio[p]);
            chk({req, " ctrl export"}, ctrl_o[p*32 +: 32], m_ctrl[p]);
        end
    endtask

    task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [1:0] sz, input bit pv, input string req);
        int  port;
        int  ofs;
        bit  mapped;
        bit  e;
        logic [31:0] exp_rd;
        port   = int'(a) / 256;
        ofs    = int'(a) % 256;
        mapped = (port < NP) && (ofs == 0 || ofs == 16);
        e      = !pv || sz != 2'b10 || !mapped || (wr && m_ctrl[port][31]);
        exp_rd = 32'h0;
        if (!e && !wr) exp_rd = (ofs == 16) ? m_ctrl[port] : m_prio[port];

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata = d; req_size = sz; req_priv = pv;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R1 done low after first edge"}, {31'b0, done}, 32'h0);
        chk({req, " R9 rdata quiet"}, rdata, 32'h0);
        chk_exports({req, " R8 pre"});
        @(negedge clk);
        chk({req, " R1 done in second cycle"}, {31'b0, done}, 32'h1);
        chk({req, " err"}, {31'b0, err}, {31'b0, e});
        chk({req, " R7/R9 rdata"}, rdata, exp_rd);
        if (!e && wr) begin
            if (ofs == 16) m_ctrl[port] = d;
            else           m_prio[port] = d;
        end
        chk_exports({req, " R8 post"});
        @(negedge clk);
        chk({req, " R1 done one cycle"}, {31'b0, done}, 32'h0);
        chk({req, " R9 rdata after"}, rdata, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_prio[p] = 32'h7654_3210;
            m_ctrl[p] = 32'h0;
        end
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 done reset", {31'b0, done}, 32'h0);
        chk("R6 err reset", {31'b0, err}, 32'h0);
        chk("R9 rdata reset", rdata, 32'h0);
        chk_exports("R6 reset");
        rst_n = 1'b1;

        // R6 / R7: reset values via reads
        access(0, 12'h000, 0, 2'b10, 1, "R6 read prio0");
        access(0, 12'h310, 0, 2'b10, 1, "R6 read ctrl3");
        access(0, 12'h500, 0, 2'b10, 1, "R6 read prio5");

        // R7: write and read back
        access(1, 12'h200, 32'h0123_4567, 2'b10, 1, "R7 write prio2");
        access(0, 12'h200, 0, 2'b10, 1, "R7 read prio2");
        access(1, 12'h410, 32'h0000_0055, 2'b10, 1, "R7 write ctrl4");
        access(0, 12'h410, 0, 2'b10, 1, "R7 read ctrl4");
        access(1, 12'h500, 32'hFEDC_BA98, 2'b10, 1, "R7 write prio5");

        // R2: unprivileged
        access(1, 12'h100, 32'hDEAD_BEEF, 2'b10, 0, "R2 unpriv write");
        access(0, 12'h200, 0, 2'b10, 0, "R2 unpriv read");

        // R3: narrow sizes
        access(1, 12'h000, 32'h1111_1111, 2'b00, 1, "R3 byte write");
        access(0, 12'h000, 0, 2'b01, 1, "R3 half read");
        access(1, 12'h010, 32'h2222_2222, 2'b11, 1, "R3 size3 write");

        // R4: unimplemented offsets
        access(0, 12'h004, 0, 2'b10, 1, "R4 offset 04");
        access(1, 12'h120, 32'h3333_3333, 2'b10, 1, "R4 offset 20");
        access(1, 12'h600, 32'h4444_4444, 2'b10, 1, "R4 port6");
        access(0, 12'h710, 0, 2'b10, 1, "R4 port7");
        access(0, 12'h800, 0, 2'b10, 1, "R4 bit11");

        // R5: lock port 1
        access(1, 12'h110, 32'h8000_0003, 2'b10, 1, "R5 set lock");
        access(1, 12'h100, 32'h5555_5555, 2'b10, 1, "R5 locked prio write");
        access(1, 12'h110, 32'h0000_0000, 2'b10, 1, "R5 locked unlock attempt");
        access(0, 12'h110, 0, 2'b10, 1, "R5 locked read ctrl");
        access(0, 12'h100, 0, 2'b10, 1, "R5 locked read prio");
        access(1, 12'h200, 32'h0BAD_F00D, 2'b10, 1, "R5 neighbour write");
        access(0, 12'h200, 0, 2'b10, 1, "R5 neighbour read");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule